// File: doc/BRIEF.md
# SPI EEPROM Boot Loader

After a reset this block copies a boot image from one serial EEPROM into on-chip instruction memory. It works out how many address bytes the EEPROM expects. It sends a read command with one zero address byte, then two, then three. The first width whose first returned data byte is not 0xFF is taken as the device's width.

With the chip select still low, it then streams the image as one continuous read. The image is a chain of blocks. Each block starts with a 10-byte header that gives a destination, a byte count and flags. The payload bytes that follow go out on a byte-wide write port. When the block flagged as final has been written, the loader raises a done flag and presents the base address of instruction memory as the place where execution starts.

A power-on or software reset latches the boot configuration pins. Any other kind of reset keeps the configuration latched earlier. A software reset with the bypass bit set skips loading altogether.

Top module: `spi_boot_loader`

## Requirements
- R1: While reset is held, and right after it, `spi_cs_n` is 1, `spi_sclk` is 0, and `mem_we`, `boot_done` and `boot_err` are 0.
- R2: `boot_mode`, `bypass_bit` and `rst_cause` are sampled only while `rst` is high. The mode is latched only when `rst_cause` is 2'b00 (power-on) or 2'b01 (software); with 2'b10 (other) the earlier value is kept. Changing the pins after reset has no effect. Only mode 2'b11 starts an SPI boot. With any other mode the block stays idle, with `spi_cs_n` high and `boot_done` low.
- R3: After a software reset (2'b01) with `bypass_bit` set, `boot_done` rises within 3 cycles of `rst` falling. `exec_addr` then equals IMEM_BASE. The chip select never falls and nothing is written.
- R4: The SPI runs in mode 0 with the MSB first. The SCLK period is DIV system clocks (DIV is even and at least 4). SCLK is high only while `spi_cs_n` is low.
- R5: Each probe sends command 0x03 followed by 1, 2 and then 3 zero address bytes. Between probes `spi_cs_n` returns high. A probe passes when the first byte after the address is not 0xFF, so a device with N address bytes causes exactly N chip-select falls.
- R6: If all three probes fail, `boot_err` goes high and stays high. `spi_cs_n` is then high, `boot_done` stays low and nothing is written.
- R7: A header is 10 bytes, little-endian. Bytes 0 to 3 are the destination address, bytes 4 to 7 the byte count, and bytes 8 and 9 the flags. Flag bit 15 marks the final block. Flag bit 0 marks a zero-fill block, which has no payload on SPI.
- R8: Payload bytes are written one per `mem_we` strobe, to the destination address and then to addresses increasing by one.
- R9: A zero-fill block writes `count` zero bytes on consecutive cycles, starting at its destination.
- R10: A block whose count is 0 writes nothing, and loading continues with the next header.
- R11: The byte that passes the probe is header byte 0. From then on `spi_cs_n` stays low until the final block is loaded.
- R12: After the final block, `boot_done` is 1 and `exec_addr` equals IMEM_BASE. `boot_done` is never high together with `boot_err` or with `mem_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_cause | input | 2 | Kind of reset: 00 power-on, 01 software, 10 other |
| boot_mode | input | 2 | Boot configuration pins; 11 selects SPI boot |
| bypass_bit | input | 1 | Skip-boot bit from the reset configuration register |
| spi_sclk | output | 1 | SPI serial clock |
| spi_mosi | output | 1 | SPI data to the EEPROM |
| spi_miso | input | 1 | SPI data from the EEPROM |
| spi_cs_n | output | 1 | Active-low EEPROM select |
| mem_we | output | 1 | Instruction memory write strobe |
| mem_addr | output | ADDR_W | Write address |
| mem_wdata | output | 8 | Write data byte |
| boot_done | output | 1 | Loading finished; execution may start |
| exec_addr | output | ADDR_W | Start address for execution |
| boot_err | output | 1 | No EEPROM responded |

## Verification
The bench builds the loader with DIV at its minimum of 4 and IMEM_BASE at 0xFFA00000. The short SCLK keeps even a three-probe boot that loads several blocks down to a few thousand cycles. The EEPROM model's address width is a run-time variable of the bench, so one build covers the 1-, 2- and 3-byte devices and the absent device. Every reset cause is applied against different pin values in the same build. This checks the latching, retention and bypass rules one after another.

// File: rtl/boot_pkg.sv
`timescale 1ns/1ps
package boot_pkg;
  localparam logic [7:0] READ_CMD   = 8'h03;
  localparam logic [1:0] MODE_SPI   = 2'b11;
  localparam logic [1:0] CAUSE_POR  = 2'b00;
  localparam logic [1:0] CAUSE_SW   = 2'b01;
  localparam int         HDR_BYTES  = 10;
  localparam int         HDR_BITS   = HDR_BYTES * 8;
  localparam int         MAX_AWIDTH = 3;

  typedef enum logic [3:0] {
    S_IDLE, S_HOLD, S_CMD, S_ADR, S_PROBE, S_GAP,
    S_HDR, S_PAY, S_ZERO, S_DONE, S_ERR
  } seq_state_t;
endpackage

// File: rtl/boot_cfg_latch.sv
`timescale 1ns/1ps
module boot_cfg_latch
  import boot_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] rst_cause_i,
  input  logic [1:0] mode_pins_i,
  input  logic       bypass_bit_i,
  output logic       spi_sel_o,
  output logic       bypass_o
);
  logic [1:0] mode_q;
  logic       byp_q;
  logic       take;

  assign take = rst && (rst_cause_i == CAUSE_POR || rst_cause_i == CAUSE_SW);

  always_ff @(posedge clk) begin
    if (take) begin
      mode_q <= mode_pins_i;
      byp_q  <= (rst_cause_i == CAUSE_SW) && bypass_bit_i;
    end
  end

  assign spi_sel_o = (mode_q == MODE_SPI);
  assign bypass_o  = byp_q;

  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $stable(mode_q) && $stable(byp_q));
endmodule

// File: rtl/spi_byte_engine.sv
`timescale 1ns/1ps
module spi_byte_engine #(
  parameter int DIV = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic [7:0] tx_i,
  input  logic       miso_i,
  output logic       sclk_o,
  output logic       mosi_o,
  output logic       busy_o,
  output logic       done_o,
  output logic [7:0] rx_o
);
  localparam int HALF = (DIV < 4) ? 2 : DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] div_q;
  logic [2:0]    bit_q;
  logic [7:0]    sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      sclk_o <= 1'b0;
      mosi_o <= 1'b0;
      done_o <= 1'b0;
      div_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      rx_o   <= '0;
    end else begin
      done_o <= 1'b0;
      if (!busy_o) begin
        if (start_i) begin
          busy_o <= 1'b1;
          sh_q   <= tx_i;
          mosi_o <= tx_i[7];
          div_q  <= '0;
          bit_q  <= '0;
          sclk_o <= 1'b0;
        end
      end else if (div_q == CW'(HALF - 1)) begin
        div_q <= '0;
        if (!sclk_o) begin
          sclk_o <= 1'b1;
          rx_o   <= {rx_o[6:0], miso_i};
        end else begin
          sclk_o <= 1'b0;
          if (bit_q == 3'd7) begin
            busy_o <= 1'b0;
            done_o <= 1'b1;
          end else begin
            bit_q  <= bit_q + 3'd1;
            sh_q   <= {sh_q[6:0], 1'b0};
            mosi_o <= sh_q[6];
          end
        end
      end else begin
        div_q <= div_q + CW'(1);
      end
    end
  end

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R4
  sclk_busy_chk: assert property (@(posedge clk) disable iff (rst)
    sclk_o |-> busy_o);
endmodule

// File: rtl/boot_sequencer.sv
`timescale 1ns/1ps
module boot_sequencer
  import boot_pkg::*;
#(
  parameter int              ADDR_W    = 32,
  parameter int              CNT_W     = 32,
  parameter int              GAP_CYC   = 4,
  parameter logic [ADDR_W-1:0] IMEM_BASE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sel_i,
  input  logic              bypass_i,
  output logic              eng_start_o,
  output logic [7:0]        eng_tx_o,
  input  logic              eng_done_i,
  input  logic [7:0]        eng_rx_i,
  output logic              cs_n_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  output logic              done_o,
  output logic              err_o,
  output logic [ADDR_W-1:0] exec_addr_o
);
  seq_state_t          state;
  logic [1:0]          wsel;
  logic [CNT_W-1:0]    idx;
  logic [HDR_BITS-1:0] hdr_q;
  logic [HDR_BITS-1:0] hdr_nx;
  logic [ADDR_W-1:0]   dst;
  logic [CNT_W-1:0]    rem;
  logic                last_q;
  logic                inflight;
  logic                want;

  assign want = (state == S_CMD) || (state == S_ADR) || (state == S_PROBE) ||
                (state == S_HDR) || (state == S_PAY);
  assign eng_start_o = want && !inflight;
  assign eng_tx_o    = (state == S_CMD) ? READ_CMD : 8'h00;
  assign hdr_nx      = {eng_rx_i, hdr_q[HDR_BITS-1:8]};

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      wsel        <= 2'd1;
      idx         <= '0;
      hdr_q       <= '0;
      dst         <= '0;
      rem         <= '0;
      last_q      <= 1'b0;
      inflight    <= 1'b0;
      cs_n_o      <= 1'b1;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
      done_o      <= 1'b0;
      err_o       <= 1'b0;
      exec_addr_o <= '0;
    end else begin
      mem_we_o <= 1'b0;
      if (eng_start_o) inflight <= 1'b1;
      else if (eng_done_i) inflight <= 1'b0;

      case (state)
        S_IDLE: begin
          if (bypass_i) state <= S_DONE;
          else if (spi_sel_i) begin
            state  <= S_CMD;
            cs_n_o <= 1'b0;
            wsel   <= 2'd1;
          end else state <= S_HOLD;
        end
        S_HOLD: state <= S_HOLD;
        S_CMD: if (eng_done_i) begin
          state <= S_ADR;
          idx   <= '0;
        end
        S_ADR: if (eng_done_i) begin
          if (idx[1:0] == wsel - 2'd1) state <= S_PROBE;
          else idx <= idx + CNT_W'(1);
        end
        S_PROBE: if (eng_done_i) begin
          if (eng_rx_i != 8'hFF) begin
            state <= S_HDR;
            hdr_q <= hdr_nx;
            idx   <= CNT_W'(1);
          end else begin
            cs_n_o <= 1'b1;
            idx    <= '0;
            if (wsel == 2'(MAX_AWIDTH)) state <= S_ERR;
            else begin
              wsel  <= wsel + 2'd1;
              state <= S_GAP;
            end
          end
        end
        S_GAP: begin
          idx <= idx + CNT_W'(1);
          if (idx == CNT_W'(GAP_CYC - 1)) begin
            state  <= S_CMD;
            cs_n_o <= 1'b0;
          end
        end
        S_HDR: if (eng_done_i) begin
          hdr_q <= hdr_nx;
          if (idx == CNT_W'(HDR_BYTES - 1)) begin
            idx    <= '0;
            dst    <= hdr_nx[ADDR_W-1:0];
            rem    <= hdr_nx[32 +: CNT_W];
            last_q <= hdr_nx[79];
            if (hdr_nx[32 +: CNT_W] == '0) begin
              if (hdr_nx[79]) begin
                state  <= S_DONE;
                cs_n_o <= 1'b1;
              end
            end else if (hdr_nx[64]) state <= S_ZERO;
            else state <= S_PAY;
          end else idx <= idx + CNT_W'(1);
        end
        S_PAY: if (eng_done_i) begin
          mem_we_o    <= 1'b1;
          mem_addr_o  <= dst;
          mem_wdata_o <= eng_rx_i;
          dst         <= dst + ADDR_W'(1);
          rem         <= rem - CNT_W'(1);
          if (rem == CNT_W'(1)) begin
            if (last_q) begin
              state  <= S_DONE;
              cs_n_o <= 1'b1;
            end else state <= S_HDR;
          end
        end
        S_ZERO: begin
          mem_we_o    <= 1'b1;
          mem_addr_o  <= dst;
          mem_wdata_o <= 8'h00;
          dst         <= dst + ADDR_W'(1);
          rem         <= rem - CNT_W'(1);
          if (rem == CNT_W'(1)) begin
            if (last_q) begin
              state  <= S_DONE;
              cs_n_o <= 1'b1;
            end else state <= S_HDR;
          end
        end
        S_DONE: begin
          cs_n_o      <= 1'b1;
          done_o      <= 1'b1;
          exec_addr_o <= IMEM_BASE;
        end
        S_ERR: begin
          cs_n_o <= 1'b1;
          err_o  <= 1'b1;
        end
        default: state <= S_HOLD;
      endcase
    end
  end

  // R11
  cs_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_HDR || state == S_PAY || state == S_ZERO) |-> !cs_n_o);
  // R9
  zero_write_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_ZERO) |=> (mem_we_o && mem_wdata_o == 8'h00));
  // R6
  err_halt_chk: assert property (@(posedge clk) disable iff (rst)
    err_o |=> (err_o && cs_n_o && !mem_we_o));
endmodule

// File: rtl/spi_boot_loader.sv
`timescale 1ns/1ps
module spi_boot_loader
  import boot_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter int                CNT_W     = 32,
  parameter int                DIV       = 4,
  parameter logic [ADDR_W-1:0] IMEM_BASE = 32'hFFA0_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        rst_cause,
  input  logic [1:0]        boot_mode,
  input  logic              bypass_bit,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              spi_cs_n,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              boot_done,
  output logic [ADDR_W-1:0] exec_addr,
  output logic              boot_err
);
  localparam int GAP_CYC = (DIV < 4) ? 4 : DIV;

  logic       spi_sel, bypass;
  logic       eng_start, eng_busy, eng_done;
  logic [7:0] eng_tx, eng_rx;

  boot_cfg_latch u_cfg (
    .clk(clk), .rst(rst), .rst_cause_i(rst_cause), .mode_pins_i(boot_mode),
    .bypass_bit_i(bypass_bit), .spi_sel_o(spi_sel), .bypass_o(bypass)
  );

  spi_byte_engine #(.DIV(DIV)) u_eng (
    .clk(clk), .rst(rst), .start_i(eng_start), .tx_i(eng_tx), .miso_i(spi_miso),
    .sclk_o(spi_sclk), .mosi_o(spi_mosi), .busy_o(eng_busy), .done_o(eng_done),
    .rx_o(eng_rx)
  );

  boot_sequencer #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .GAP_CYC(GAP_CYC), .IMEM_BASE(IMEM_BASE)
  ) u_seq (
    .clk(clk), .rst(rst), .spi_sel_i(spi_sel), .bypass_i(bypass),
    .eng_start_o(eng_start), .eng_tx_o(eng_tx), .eng_done_i(eng_done),
    .eng_rx_i(eng_rx), .cs_n_o(spi_cs_n), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .done_o(boot_done),
    .err_o(boot_err), .exec_addr_o(exec_addr)
  );

  // R4
  sclk_cs_chk: assert property (@(posedge clk) disable iff (rst)
    spi_sclk |-> !spi_cs_n);
  // R4
  start_idle_chk: assert property (@(posedge clk) disable iff (rst)
    eng_start |-> !eng_busy);
  // R12
  done_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(boot_done && boot_err));
  // R12
  done_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    boot_done |-> !mem_we);
  // R8
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(1)));
endmodule

// File: tb/sim_spi_boot_loader.sv
`timescale 1ns/1ps
module sim_spi_boot_loader;
  localparam int          DIV  = 4;
  localparam logic [31:0] BASE = 32'hFFA0_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  rst_cause = 2'b00;
  logic [1:0]  boot_mode = 2'b11;
  logic        bypass_bit = 1'b0;
  logic        spi_sclk, spi_mosi, spi_cs_n, mem_we, boot_done, boot_err;
  logic        spi_miso = 1'b1;
  logic [31:0] mem_addr, exec_addr;
  logic [7:0]  mem_wdata;

  always #2.5 clk = ~clk;

  spi_boot_loader #(.DIV(DIV), .IMEM_BASE(BASE)) u0 (
    .clk(clk), .rst(rst), .rst_cause(rst_cause), .boot_mode(boot_mode),
    .bypass_bit(bypass_bit), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_cs_n(spi_cs_n), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .boot_done(boot_done),
    .exec_addr(exec_addr), .boot_err(boot_err)
  );

  int checks = 0, errors = 0;
  int img_len = 0, aw_dev = 1;
  logic [7:0]  img [0:255];
  logic [39:0] exp_q [$];
  int writes = 0, cs_falls = 0, bad_writes = 0;
  logic cs_prev = 1'b1;
  real t_r0 = 0.0, t_r1 = 0.0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic put_byte(input logic [7:0] b);
    img[img_len] = b;
    img_len++;
  endtask

  // driver: builds header/payload and pushes the expected writes
  task automatic add_block(input logic [31:0] dest, input int cnt,
                           input logic [15:0] flags, input int seed);
    for (int i = 0; i < 4; i++) put_byte(dest[8*i +: 8]);
    for (int i = 0; i < 4; i++) put_byte(8'((cnt >> (8*i)) & 255));
    put_byte(flags[7:0]);
    put_byte(flags[15:8]);
    for (int i = 0; i < cnt; i++) begin
      logic [7:0] b;
      b = 8'((seed + i * 13) & 255);
      if (flags[0]) exp_q.push_back({dest + 32'(i), 8'h00});
      else begin
        put_byte(b);
        exp_q.push_back({dest + 32'(i), b});
      end
    end
  endtask

  // EEPROM model, mode 0
  int         bitn = 0;
  logic [7:0] cmd_sr = 8'h00;

  function automatic logic model_bit(input int n);
    int st, k;
    if (spi_cs_n || aw_dev == 0 || cmd_sr != 8'h03) return 1'b1;
    st = 8 + 8 * aw_dev;
    if (n < st) return 1'b1;
    k = n - st;
    if (k / 8 >= img_len) return 1'b1;
    return img[k / 8][7 - (k % 8)];
  endfunction

  always @(posedge spi_sclk or posedge spi_cs_n) begin
    if (spi_cs_n) begin
      bitn   <= 0;
      cmd_sr <= 8'h00;
    end else begin
      if (bitn < 8) cmd_sr <= {cmd_sr[6:0], spi_mosi};
      if (bitn == 0) t_r0 <= $realtime;
      if (bitn == 1) t_r1 <= $realtime;
      bitn <= bitn + 1;
    end
  end

  always @(negedge spi_sclk or posedge spi_cs_n) spi_miso <= model_bit(bitn);

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (cs_prev && !spi_cs_n) cs_falls++;
      if (mem_we) begin
        writes++;
        if (exp_q.size() == 0) begin
          bad_writes++;
          $display("FAIL R8 unexpected write actual=%0h expected=none", {mem_addr, mem_wdata});
          errors++;
          checks++;
        end else begin
          logic [39:0] e;
          e = exp_q.pop_front();
          chk({mem_addr, mem_wdata} == e, "R8", "write", {mem_addr, mem_wdata}, e);
        end
      end
    end
    cs_prev = spi_cs_n;
  end

  task automatic do_reset(input logic [1:0] cause, input logic [1:0] mode, input logic byp);
    @(negedge clk);
    rst = 1'b1; rst_cause = cause; boot_mode = mode; bypass_bit = byp;
    repeat (4) @(negedge clk);
    writes = 0; cs_falls = 0; bad_writes = 0;
    rst = 1'b0;
  endtask

  task automatic wait_end(input int maxc);
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      if (boot_done || boot_err) break;
    end
  endtask

  task automatic check_loaded(input string req, input int falls);
    chk(boot_done === 1'b1, "R12", {req, " done"}, 64'(boot_done), 1);
    chk(boot_err === 1'b0, "R12", {req, " err"}, 64'(boot_err), 0);
    chk(exec_addr === BASE, "R12", {req, " exec_addr"}, 64'(exec_addr), 64'(BASE));
    chk(exp_q.size() == 0, "R8", {req, " writes left"}, 64'(exp_q.size()), 0);
    chk(cs_falls == falls, "R5", {req, " cs falls"}, 64'(cs_falls), 64'(falls));
    chk(spi_cs_n === 1'b1, "R11", {req, " cs released"}, 64'(spi_cs_n), 1);
  endtask

  task automatic image1();
    img_len = 0; exp_q.delete();
    add_block(BASE + 32'h10, 3, 16'h0000, 5);
    add_block(BASE + 32'h40, 0, 16'h0000, 0);    // R10 empty block
    add_block(BASE + 32'h80, 4, 16'h8001, 0);    // R9 zero-fill, final
  endtask

  initial begin
    #750000;
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(spi_cs_n === 1'b1 && spi_sclk === 1'b0, "R1", "cs/sclk in reset", {spi_cs_n, spi_sclk}, 2'b10);
    chk(mem_we === 1'b0 && boot_done === 1'b0 && boot_err === 1'b0, "R1", "we/done/err in reset",
        {mem_we, boot_done, boot_err}, 0);

    // 1-byte device, multi-block image, pins changed mid-boot (R2, R7, R9, R10)
    aw_dev = 1; image1();
    do_reset(2'b00, 2'b11, 1'b0);
    @(negedge clk);
    chk(spi_cs_n === 1'b1 || spi_sclk === 1'b0, "R1", "after reset", {spi_cs_n, spi_sclk}, 2'b10);
    repeat (150) @(negedge clk);
    boot_mode = 2'b00; bypass_bit = 1'b1;
    wait_end(20000);
    check_loaded("R7 aw1", 1);
    chk(t_r1 - t_r0 == 5.0 * DIV, "R4", "sclk period ns", 64'(int'(t_r1 - t_r0)), 64'(5 * DIV));

    // 2-byte device
    aw_dev = 2; img_len = 0; exp_q.delete();
    add_block(BASE + 32'h200, 5, 16'h8000, 77);
    do_reset(2'b00, 2'b11, 1'b0);
    wait_end(20000);
    check_loaded("R5 aw2", 2);

    // 3-byte device
    aw_dev = 3; img_len = 0; exp_q.delete();
    add_block(BASE + 32'h300, 2, 16'h0000, 200);
    add_block(BASE + 32'h310, 3, 16'h0001, 0);
    add_block(BASE + 32'h320, 1, 16'h8000, 9);
    do_reset(2'b00, 2'b11, 1'b0);
    wait_end(20000);
    check_loaded("R11 aw3", 3);

    // no device
    aw_dev = 0; img_len = 0; exp_q.delete();
    do_reset(2'b00, 2'b11, 1'b0);
    wait_end(20000);
    repeat (20) @(negedge clk);
    chk(boot_err === 1'b1 && boot_done === 1'b0, "R6", "err/done", {boot_err, boot_done}, 2'b10);
    chk(writes == 0 && cs_falls == 3 && spi_cs_n === 1'b1, "R6", "writes/falls/cs",
        {32'(writes), 8'(cs_falls), 7'd0, spi_cs_n}, {32'd0, 8'd3, 8'd1});

    // software reset with bypass
    aw_dev = 1; image1(); exp_q.delete();
    do_reset(2'b01, 2'b11, 1'b1);
    repeat (3) @(negedge clk);
    chk(boot_done === 1'b1 && exec_addr === BASE, "R3", "bypass done", {boot_done, exec_addr}, {1'b1, BASE});
    repeat (50) @(negedge clk);
    chk(cs_falls == 0 && writes == 0, "R3", "bypass no activity", {32'(cs_falls), 32'(writes)}, 0);

    // software reset without bypass reloads
    image1();
    do_reset(2'b01, 2'b11, 1'b0);
    wait_end(20000);
    check_loaded("R2 sw", 1);

    // non-SPI mode stays idle
    image1();
    do_reset(2'b00, 2'b01, 1'b0);
    repeat (300) @(negedge clk);
    chk(cs_falls == 0 && boot_done === 1'b0 && boot_err === 1'b0 && spi_cs_n === 1'b1, "R2",
        "idle mode", {32'(cs_falls), boot_done, boot_err, spi_cs_n}, {32'd0, 3'b001});

    // other reset cause keeps the latched non-SPI mode
    do_reset(2'b10, 2'b11, 1'b1);
    repeat (300) @(negedge clk);
    chk(cs_falls == 0 && boot_done === 1'b0 && writes == 0, "R2", "other cause retained",
        {32'(cs_falls), 31'(writes), boot_done}, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule